// File: doc/BRIEF.md
# Debug Write Command Engine

This engine sits behind the byte-level receiver of a debug port. It turns a stream of host command bytes into single write accesses. A memory-write command carries a 24-bit target address and one, two or four data bytes. The engine forces the address onto the boundary of the access size and presents one request on a simple memory write port. It holds that request until the memory side acknowledges it. The status form of the command then sends the core status byte back to the host.

A register-write command carries the register number in the low nibble of its opcode and four data bytes. It produces a one-cycle write strobe on a register-file port, but only when the core was halted as the opcode arrived. Any other opcode raises a one-cycle illegal flag, and the engine goes back to waiting for an opcode.

Top module: `dbg_write_engine`

## Requirements
- R1: After reset, `mem_req`, `reg_we`, `tx_valid` and `illegal` are all low, and the engine waits for an opcode.
- R2: Opcodes 0x10/0x11 select byte size, 0x14/0x15 word size and 0x18/0x19 longword size. `mem_size` shows 0, 1 or 2 respectively. Exactly 1, 2 or 4 data bytes follow the address.
- R3: The three bytes after a memory opcode form the 24-bit address, sent most significant byte first.
- R4: The data bytes arrive most significant first and are presented right-justified on `mem_data`, with the unused upper bits zero.
- R5: `mem_addr` has bit 0 cleared for word accesses and bits 1..0 cleared for longword accesses. Byte accesses keep all address bits.
- R6: `mem_req` rises on the cycle after the last data byte is taken. It stays high, with stable address, size and data, until a cycle in which `mem_ack` is high, and it drops after that cycle.
- R7: For the status opcodes (opcode bit 0 set), `tx_valid` pulses for one cycle after the acknowledge cycle. `tx_byte` then carries the `core_status` value seen in the acknowledge cycle. The non-status opcodes never assert `tx_valid`.
- R8: When the core is halted, opcode 0x40+n (n = 0..15) followed by four data bytes pulses `reg_we` for one cycle. That pulse carries `reg_idx` = n and `reg_data` = the four bytes, first byte in bits 31..24.
- R9: When the core is not halted, a 0x40..0x4F opcode pulses `illegal` on the next cycle. The four following bytes are consumed and discarded, and `reg_we` stays low.
- R10: Any other opcode pulses `illegal` for one cycle. The next byte is decoded as a fresh opcode.
- R11: Bytes that arrive while a memory request is waiting for its acknowledge are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| core_halted | input | 1 | Core is halted |
| core_status | input | 8 | Core status byte |
| tx_valid | output | 1 | Status byte valid (one cycle) |
| tx_byte | output | 8 | Status byte to host |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 24 | Aligned write address |
| mem_size | output | 2 | 0 byte, 1 word, 2 longword |
| mem_data | output | 32 | Right-justified write data |
| mem_ack | input | 1 | Memory write acknowledge |
| reg_we | output | 1 | Register write strobe |
| reg_idx | output | 4 | Register number (0-7 data, 8-15 address) |
| reg_data | output | 32 | Register write data |
| illegal | output | 1 | Illegal command pulse |

## Verification
The bench sweeps every size and status variant over addresses with all four low-bit patterns. A design that drops the wrong address bits, or takes the wrong number of data bytes, would misplace the write and misread the next command. The acknowledge is held back and the status input is changed just before it. A design that releases the request early, or samples the status too soon, sends the wrong byte. All sixteen register numbers are written while halted and again while running, and all 256 opcodes go through the illegal sweep. A design that fails to drain a rejected register write would misdecode its data bytes as opcodes. Stray bytes sent during a pending request would corrupt the following command if they were consumed.

// File: rtl/dbg_write_engine.sv
module dbg_write_engine #(
  parameter int ADDR_BYTES = 3,
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_byte,
  input  logic                    core_halted,
  input  logic [7:0]              core_status,
  output logic                    tx_valid,
  output logic [7:0]              tx_byte,
  output logic                    mem_req,
  output logic [ADDR_BYTES*8-1:0] mem_addr,
  output logic [1:0]              mem_size,
  output logic [DATA_BYTES*8-1:0] mem_data,
  input  logic                    mem_ack,
  output logic                    reg_we,
  output logic [3:0]              reg_idx,
  output logic [DATA_BYTES*8-1:0] reg_data,
  output logic                    illegal
);
  localparam int AW = ADDR_BYTES * 8;
  localparam int DW = DATA_BYTES * 8;
  localparam int CW = $clog2(DATA_BYTES > ADDR_BYTES ? DATA_BYTES : ADDR_BYTES);

  typedef enum logic [2:0] {IDLE, ADDR, DATA, REQ, RDAT, DRAIN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic [1:0]    size;
  logic          ws;
  logic [3:0]    ridx;
  logic          is_mem, is_reg;
  logic [CW-1:0] last_data;

  assign is_mem = rx_byte[7:4] == 4'h1 && !rx_byte[1] && rx_byte[3:2] != 2'b11;
  assign is_reg = rx_byte[7:4] == 4'h4;
  assign last_data = size == 2'd0 ? CW'(0) : size == 2'd1 ? CW'(1) : CW'(3);

  assign mem_req  = st == REQ;
  assign mem_size = size;
  assign mem_data = data;
  assign mem_addr = {addr[AW-1:2], addr[1] & (size != 2'd2), addr[0] & (size == 2'd0)};
  assign reg_idx  = ridx;
  assign reg_data = data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      addr     <= '0;
      data     <= '0;
      size     <= '0;
      ws       <= 1'b0;
      ridx     <= '0;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
      reg_we   <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      reg_we   <= 1'b0;
      illegal  <= 1'b0;
      case (st)
        IDLE: if (rx_valid) begin
          if (is_mem) begin
            size <= rx_byte[3:2];
            ws   <= rx_byte[0];
            cnt  <= CW'(ADDR_BYTES - 1);
            data <= '0;
            st   <= ADDR;
          end else if (is_reg) begin
            ridx <= rx_byte[3:0];
            cnt  <= CW'(DATA_BYTES - 1);
            data <= '0;
            if (core_halted) st <= RDAT;
            else begin
              illegal <= 1'b1;
              st      <= DRAIN;
            end
          end else begin
            illegal <= 1'b1;
          end
        end
        ADDR: if (rx_valid) begin
          addr <= {addr[AW-9:0], rx_byte};
          if (cnt == '0) begin
            cnt <= last_data;
            st  <= DATA;
          end else cnt <= cnt - 1'b1;
        end
        DATA: if (rx_valid) begin
          data <= {data[DW-9:0], rx_byte};
          if (cnt == '0) st <= REQ;
          else cnt <= cnt - 1'b1;
        end
        REQ: if (mem_ack) begin
          st <= IDLE;
          if (ws) begin
            tx_valid <= 1'b1;
            tx_byte  <= core_status;
          end
        end
        RDAT: if (rx_valid) begin
          data <= {data[DW-9:0], rx_byte};
          if (cnt == '0) begin
            reg_we <= 1'b1;
            st     <= IDLE;
          end else cnt <= cnt - 1'b1;
        end
        DRAIN: if (rx_valid) begin
          if (cnt == '0) st <= IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_data) && $stable(mem_size));

  // R6
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req);

  // R5
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_size != 2'd1 || !mem_addr[0]) && (mem_size != 2'd2 || mem_addr[1:0] == 2'b00));

  // R7
  status_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(mem_req && mem_ack));

  // R8
  reg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R10
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !illegal);

  // R1
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, reg_we, tx_valid, illegal}));
endmodule

// File: tb/dbg_write_engine_tb_top.sv
`timescale 1ns/1ps
module dbg_write_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic core_halted = 1'b0;
  logic [7:0] core_status = '0;
  logic tx_valid, mem_req, mem_ack = 1'b0, reg_we, illegal;
  logic [7:0] tx_byte;
  logic [23:0] mem_addr;
  logic [1:0] mem_size;
  logic [31:0] mem_data, reg_data;
  logic [3:0] reg_idx;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dbg_write_engine dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .core_halted(core_halted), .core_status(core_status),
    .tx_valid(tx_valid), .tx_byte(tx_byte),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_data(mem_data), .mem_ack(mem_ack),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_data(reg_data), .illegal(illegal));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic mem_cmd(input logic [7:0] op, input logic [23:0] a, input logic [31:0] d, input logic [7:0] st);
    int n = op[3:2] == 2'd0 ? 1 : op[3:2] == 2'd1 ? 2 : 4;
    logic [31:0] dm = n == 4 ? d : d & ((32'd1 << (8 * n)) - 1);
    logic [23:0] am = a & ~24'(n - 1);
    send(op);
    for (int i = 2; i >= 0; i--) send(a[8*i +: 8]);
    for (int i = n - 1; i >= 0; i--) begin
      chk(!mem_req, "R2", {31'd0, mem_req}, 32'd0);
      send(d[8*i +: 8]);
    end
    chk(mem_req, "R6", {31'd0, mem_req}, 32'd1);
    chk(mem_size == op[3:2], "R2", {30'd0, mem_size}, {30'd0, op[3:2]});
    chk(mem_addr == am, "R5 R3", {8'd0, mem_addr}, {8'd0, am});
    chk(mem_data == dm, "R4", mem_data, dm);
    core_status = ~st;
    send(8'h10);
    chk(mem_req && mem_addr == am && mem_data == dm, "R6 R11", {31'd0, mem_req}, 32'd1);
    core_status = st;
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    chk(!mem_req, "R6", {31'd0, mem_req}, 32'd0);
    chk(tx_valid == op[0], "R7", {31'd0, tx_valid}, {31'd0, op[0]});
    if (op[0]) chk(tx_byte == st, "R7", {24'd0, tx_byte}, {24'd0, st});
    @(negedge clk);
    chk(!tx_valid && !illegal, "R7 R11", {30'd0, tx_valid, illegal}, 32'd0);
  endtask

  task automatic reg_cmd(input logic [3:0] n, input logic [31:0] d);
    bit saw = 1'b0;
    send(8'h40 | 8'(n));
    chk(illegal == !core_halted, "R9", {31'd0, illegal}, {31'd0, !core_halted});
    for (int i = 3; i >= 0; i--) begin
      saw |= reg_we;
      send(d[8*i +: 8]);
    end
    if (core_halted) begin
      chk(reg_we && reg_idx == n && reg_data == d, "R8", reg_data, d);
      @(negedge clk);
      chk(!reg_we, "R8", {31'd0, reg_we}, 32'd0);
    end else begin
      chk(!reg_we && !saw && !illegal, "R9", {31'd0, reg_we}, 32'd0);
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] ops[6] = '{8'h10, 8'h11, 8'h14, 8'h15, 8'h18, 8'h19};
    @(negedge clk);
    @(negedge clk);
    // R1
    chk(!mem_req && !reg_we && !tx_valid && !illegal, "R1",
        {28'd0, mem_req, reg_we, tx_valid, illegal}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int o = 0; o < 6; o++)
      for (int lo = 0; lo < 4; lo++)
        mem_cmd(ops[o], 24'h5A3C00 + 24'(lo) + 24'(o << 12), 32'h89ABCDEF ^ 32'(o * 77 + lo), 8'(8'hC0 + o * 4 + lo));
    core_halted = 1'b1;
    for (int r = 0; r < 16; r++) reg_cmd(4'(r), 32'h10203040 * 32'(r + 1) ^ 32'h10);
    core_halted = 1'b0;
    for (int r = 0; r < 16; r++) reg_cmd(4'(r), 32'h10111840);
    mem_cmd(8'h19, 24'hFFFFFF, 32'h01020304, 8'h3E);
    for (int op = 0; op < 256; op++) begin
      logic [7:0] b = 8'(op);
      bit known = (b[7:4] == 4'h1 && !b[1] && b[3:2] != 2'b11) || b[7:4] == 4'h4;
      if (!known) begin
        send(b);
        // R10
        chk(illegal, "R10", {31'd0, illegal}, 32'd1);
        @(negedge clk);
        chk(!illegal, "R10", {31'd0, illegal}, 32'd0);
      end
    end
    mem_cmd(8'h14, 24'h000003, 32'h0000BEEF, 8'h00);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule